// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible face of a simple byte-wide UART. It sits between a 32-bit, word-only register bus and a separate serial engine. It holds five registers: a data register, a baud divisor, a status register, a control register and a debug register. It also keeps two event flags, one for receive and one for transmit, and it drives a single level interrupt. The serial engine is reached through two handshakes. On the transmit side the block sends a one-cycle strobe together with a byte. On the receive side the engine offers a byte with a valid signal, and the block answers with a ready signal.

Receive holding is a single byte with no queue. The receive event flag is the back-pressure: while it is set, no further byte is taken. Software clears the event flags by writing ones to the status register. The transmit-holding-empty status bit always reads as one. The divisor, the passthrough enable and the break enable are stored here and driven out to neighbouring logic. Their behaviour is implemented outside this block.

Top module: `uart_csr_front`

## Requirements
- R1: After a synchronous reset, the data, divisor, control and debug registers all read 0. The status register reads 1 (bit 0 set). `irq` is low and `rx_ready` is high.
- R2: A write to word index 0 sets the transmit event flag (status bit 2). In the following cycle it raises `tx_strobe` for exactly one cycle, with `tx_byte` equal to the low 8 bits of the written value.
- R3: When `rx_valid` and `rx_ready` are both high at a clock edge, `rx_byte` is captured, the receive event flag (status bit 1) is set, and `rx_ready` goes low.
- R4: While the receive event flag is set, `rx_ready` is low and offered bytes are ignored. The captured byte does not change.
- R5: A write to the status register (index 2) clears the receive event when bit 1 of the written value is 1. It clears the transmit event when bit 2 is 1. Zero bits leave their flag unchanged, and bit 0 stays 1 whatever is written.
- R6: `irq` is high exactly when (control bit 0 AND receive event) OR (control bit 1 AND transmit event). It follows any change of those bits with no extra delay.
- R7: The divisor (index 1), control (index 3) and debug (index 4) registers store and return all 32 written bits. `baud_div` shows the divisor, `thru_en` shows control bit 2, and `break_en` shows debug bit 0.
- R8: Read data appears on `bus_rdata` in the cycle after the edge that sampled `bus_rd`. In every other cycle it is 0. A read of an unmapped index (5 or above) returns 0 and changes nothing.
- R9: The register index is the byte address shifted right by two, so address bits 1:0 do not matter. A write to an unmapped index changes no register or output.
- R10: A read of index 0 returns the last received byte, zero-extended. Writing index 0 does not change this value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, 0 when not reading |
| tx_strobe | output | 1 | One-cycle pulse handing a byte to the transmitter |
| tx_byte | output | BYTE_W | Byte for the transmitter |
| rx_valid | input | 1 | Serial engine offers a received byte |
| rx_byte | input | BYTE_W | Received byte |
| rx_ready | output | 1 | High while the receive event flag is clear |
| baud_div | output | DATA_W | Divisor register contents |
| thru_en | output | 1 | Passthrough enable (control bit 2) |
| break_en | output | 1 | Break enable (debug bit 0) |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, event flags, the captured byte and the transmit strobe each land one rising edge after the stimulus was sampled. `irq` and `rx_ready` are combinational from those flags, so they move in the same cycle as the flags. Read data is due one edge after the read strobe. The bench applies stimulus on falling edges and advances a behavioural model at each rising edge. At the next falling edge it compares every output against that model, so each result is checked in exactly the cycle it falls due. Directed reads against literal values additionally pin the reset values, the write-one-to-clear behaviour and the address aliasing.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int IDX_W    = 3;
    localparam int NUM_REGS = 5;

    typedef enum logic [IDX_W-1:0] {
        IDX_DATA = 3'd0,
        IDX_DIV  = 3'd1,
        IDX_STAT = 3'd2,
        IDX_CTRL = 3'd3,
        IDX_DBG  = 3'd4
    } reg_idx_e;

    // status bit positions
    localparam int ST_THRE = 0;
    localparam int ST_RXEV = 1;
    localparam int ST_TXEV = 2;
    localparam int ST_W    = 3;

    // control and debug bit positions
    localparam int CT_RXIE = 0;
    localparam int CT_TXIE = 1;
    localparam int CT_THRU = 2;
    localparam int DB_BRK  = 0;

    // slots of the plain read/write storage array
    localparam int RW_DIV  = 0;
    localparam int RW_CTRL = 1;
    localparam int RW_DBG  = 2;
    localparam int NUM_RW  = 3;

    typedef struct packed {
        logic data;
        logic div;
        logic stat;
        logic ctrl;
        logic dbg;
    } wr_sel_t;

    function automatic logic [ST_W-1:0] status_bits(input logic tx_ev, input logic rx_ev);
        logic [ST_W-1:0] s;
        s          = '0;
        s[ST_THRE] = 1'b1;
        s[ST_RXEV] = rx_ev;
        s[ST_TXEV] = tx_ev;
        return s;
    endfunction

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output wr_sel_t           wsel,
    output reg_idx_e          ridx,
    output logic              rd_hit
);
    logic [ADDR_W-1:0] word_addr;
    logic              mapped;

    assign word_addr = addr >> 2;
    assign mapped    = (word_addr < ADDR_W'(NUM_REGS));
    assign ridx      = reg_idx_e'(word_addr[IDX_W-1:0]);
    assign rd_hit    = rd & mapped;

    always_comb begin
        wsel = '0;
        if (wr && mapped) begin
            case (ridx)
                IDX_DATA: wsel.data = 1'b1;
                IDX_DIV:  wsel.div  = 1'b1;
                IDX_STAT: wsel.stat = 1'b1;
                IDX_CTRL: wsel.ctrl = 1'b1;
                IDX_DBG:  wsel.dbg  = 1'b1;
                default:  wsel = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_csr_word.sv
module uart_csr_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/uart_csr_events.sv
module uart_csr_events (
    input  logic clk,
    input  logic rst,
    input  logic set_tx,
    input  logic clr_tx,
    input  logic clr_rx,
    input  logic rx_valid,
    input  logic rx_ie,
    input  logic tx_ie,
    output logic rx_evt,
    output logic tx_evt,
    output logic rx_ready,
    output logic accept,
    output logic irq
);
    assign rx_ready = ~rx_evt;
    assign accept   = rx_valid & rx_ready;
    assign irq      = (rx_ie & rx_evt) | (tx_ie & tx_evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_evt <= 1'b0;
            tx_evt <= 1'b0;
        end else begin
            if (accept)      rx_evt <= 1'b1;
            else if (clr_rx) rx_evt <= 1'b0;
            if (set_tx)      tx_evt <= 1'b1;
            else if (clr_tx) tx_evt <= 1'b0;
        end
    end

    // R3: an accepted byte raises the receive event
    a_r3_rx_capture: assert property (@(posedge clk) disable iff (rst)
        accept |=> rx_evt);
    // R5: a one in bit 1 drops a pending receive event
    a_r5_clear_rx: assert property (@(posedge clk) disable iff (rst)
        (clr_rx && rx_evt) |=> !rx_evt);
    // R5: a one in bit 2 drops the transmit event
    a_r5_clear_tx: assert property (@(posedge clk) disable iff (rst)
        (clr_tx && !set_tx) |=> !tx_evt);
    // R2: a data write raises the transmit event
    a_r2_tx_flag: assert property (@(posedge clk) disable iff (rst)
        set_tx |=> tx_evt);
endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic [DATA_W-1:0] baud_div,
    output logic              thru_en,
    output logic              break_en,
    output logic              irq
);
    localparam int PAD_RX = DATA_W - BYTE_W;
    localparam int PAD_ST = DATA_W - ST_W;

    wr_sel_t           wsel;
    reg_idx_e          ridx;
    logic              rd_hit;
    logic [NUM_RW-1:0] rw_we;
    logic [DATA_W-1:0] rw_q [NUM_RW];
    logic              rx_evt, tx_evt, accept;
    logic [BYTE_W-1:0] rx_q;

    uart_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wsel   (wsel),
        .ridx   (ridx),
        .rd_hit (rd_hit)
    );

    always_comb begin
        rw_we          = '0;
        rw_we[RW_DIV]  = wsel.div;
        rw_we[RW_CTRL] = wsel.ctrl;
        rw_we[RW_DBG]  = wsel.dbg;
    end

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        uart_csr_word #(.W(DATA_W)) u_word (
            .clk (clk),
            .rst (rst),
            .we  (rw_we[g]),
            .d   (bus_wdata),
            .q   (rw_q[g])
        );
    end

    uart_csr_events u_events (
        .clk      (clk),
        .rst      (rst),
        .set_tx   (wsel.data),
        .clr_tx   (wsel.stat & bus_wdata[ST_TXEV]),
        .clr_rx   (wsel.stat & bus_wdata[ST_RXEV]),
        .rx_valid (rx_valid),
        .rx_ie    (rw_q[RW_CTRL][CT_RXIE]),
        .tx_ie    (rw_q[RW_CTRL][CT_TXIE]),
        .rx_evt   (rx_evt),
        .tx_evt   (tx_evt),
        .rx_ready (rx_ready),
        .accept   (accept),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q      <= '0;
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            if (accept) rx_q <= rx_byte;
            tx_strobe <= wsel.data;
            if (wsel.data) tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_hit) begin
            bus_rdata <= '0;
        end else begin
            case (ridx)
                IDX_DATA: bus_rdata <= {{PAD_RX{1'b0}}, rx_q};
                IDX_DIV:  bus_rdata <= rw_q[RW_DIV];
                IDX_STAT: bus_rdata <= {{PAD_ST{1'b0}}, status_bits(tx_evt, rx_evt)};
                IDX_CTRL: bus_rdata <= rw_q[RW_CTRL];
                IDX_DBG:  bus_rdata <= rw_q[RW_DBG];
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assign baud_div = rw_q[RW_DIV];
    assign thru_en  = rw_q[RW_CTRL][CT_THRU];
    assign break_en = rw_q[RW_DBG][DB_BRK];

    // R4: a held byte cannot be overwritten while not ready
    a_r4_hold_byte: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |=> $stable(rx_q));
    // R6: the interrupt is never raised without a pending event
    a_r6_irq_needs_event: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rx_evt || tx_evt));
    // R8: read data is zero after a cycle without a read
    a_r8_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
    // R2: a data write is followed by the transmit strobe
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && wsel.data) |=> tx_strobe);
endmodule

// File: tb/test_uart_csr_front.sv
module test_uart_csr_front;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic [31:0] baud_div;
    logic        thru_en, break_en, irq;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_div, m_ctrl, m_dbg, m_rxd, m_rdata, m_txb;
    bit m_rxev, m_txev, m_strobe;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_csr_front i_uart_csr_front (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_strobe(tx_strobe),
        .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .baud_div(baud_div), .thru_en(thru_en), .break_en(break_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input int idx);
        case (idx)
            0: return m_rxd;
            1: return m_div;
            2: return 1 + (m_rxev ? 2 : 0) + (m_txev ? 4 : 0);
            3: return m_ctrl;
            4: return m_dbg;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int idx;
        bit take;
        idx = int'(bus_addr) / 4;
        if (rst) begin
            m_div = 0; m_ctrl = 0; m_dbg = 0; m_rxd = 0; m_rdata = 0; m_txb = 0;
            m_rxev = 0; m_txev = 0; m_strobe = 0;
            return;
        end
        m_rdata  = bus_rd ? model_read(idx) : 0;
        m_strobe = bus_wr && idx == 0;
        if (m_strobe) m_txb = int'(bus_wdata) & 255;
        take = rx_valid && !m_rxev;
        if (take) m_rxd = int'(rx_byte);
        if (bus_wr) begin
            if (idx == 1) m_div = int'(bus_wdata);
            if (idx == 3) m_ctrl = int'(bus_wdata);
            if (idx == 4) m_dbg = int'(bus_wdata);
        end
        if (take) m_rxev = 1;
        else if (bus_wr && idx == 2 && bus_wdata[1]) m_rxev = 0;
        if (m_strobe) m_txev = 1;
        else if (bus_wr && idx == 2 && bus_wdata[2]) m_txev = 0;
    endtask

    task automatic compare_all();
        bit exp_irq;
        exp_irq = (m_ctrl[0] && m_rxev) || (m_ctrl[1] && m_txev);
        chk("R6 irq", 32'(irq), 32'(exp_irq));
        chk("R4 rx_ready", 32'(rx_ready), 32'(!m_rxev));
        chk("R2 tx_strobe", 32'(tx_strobe), 32'(m_strobe));
        if (m_strobe) chk("R2 tx_byte", 32'(tx_byte), 32'(m_txb));
        chk("R8 bus_rdata", bus_rdata, m_rdata);
        chk("R7 baud_div", baud_div, m_div);
        chk("R7 thru_en", 32'(thru_en), 32'(m_ctrl[2]));
        chk("R7 break_en", 32'(break_en), 32'(m_dbg[0]));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cycle();
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        cycle();
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        cycle(); cycle();
        rst = 1'b0;
        cycle();
        // R1 reset values
        do_read(5'h00, 32'h0, "R1 data reset");
        do_read(5'h04, 32'h0, "R1 div reset");
        do_read(5'h08, 32'h1, "R1 status reset");
        do_read(5'h0C, 32'h0, "R1 ctrl reset");
        do_read(5'h10, 32'h0, "R1 dbg reset");
        chk("R1 rx_ready reset", 32'(rx_ready), 32'h1);
        // R7 plain storage
        do_write(5'h04, 32'h1234_5678);
        do_write(5'h0C, 32'hF0F0_0004);
        do_write(5'h10, 32'h8000_0001);
        do_read(5'h04, 32'h1234_5678, "R7 div readback");
        do_read(5'h0C, 32'hF0F0_0004, "R7 ctrl readback");
        do_read(5'h10, 32'h8000_0001, "R7 dbg readback");
        chk("R7 thru_en", 32'(thru_en), 32'h1);
        // R2 transmit
        do_write(5'h00, 32'h0000_A5C3);
        chk("R2 strobe byte", 32'(tx_byte), 32'hC3);
        cycle();
        chk("R2 strobe single", 32'(tx_strobe), 32'h0);
        do_read(5'h08, 32'h5, "R2 tx event");
        // R6 tx interrupt, R5 clear tx
        do_write(5'h0C, 32'h2);
        chk("R6 irq tx", 32'(irq), 32'h1);
        do_write(5'h08, 32'h4);
        chk("R6 irq dropped", 32'(irq), 32'h0);
        do_read(5'h08, 32'h1, "R5 tx cleared");
        // R3 receive
        do_write(5'h0C, 32'h1);
        rx_byte = 8'h3C; rx_valid = 1'b1;
        cycle();
        chk("R3 ready low", 32'(rx_ready), 32'h0);
        chk("R6 irq rx", 32'(irq), 32'h1);
        // R4 further bytes blocked
        rx_byte = 8'h99;
        cycle(); cycle();
        do_read(5'h00, 32'h3C, "R4 byte held");
        // R10 data write leaves received byte
        do_write(5'h00, 32'h77);
        do_read(5'h00, 32'h3C, "R10 rx byte after tx");
        // R5 zero bits and bit 0 have no effect
        do_write(5'h08, 32'hFFFF_FFF9);
        do_read(5'h08, 32'h7, "R5 no clear");
        do_write(5'h08, 32'h2);
        chk("R5 rx cleared ready", 32'(rx_ready), 32'h1);
        cycle();
        rx_valid = 1'b0;
        do_read(5'h00, 32'h99, "R3 second byte");
        // R9 aliasing and unmapped indices
        do_read(5'h0B, 32'h7, "R9 low bits ignored");
        do_read(5'h1C, 32'h0, "R8 unmapped read");
        do_write(5'h14, 32'hFFFF_FFFF);
        do_write(5'h1F, 32'hFFFF_FFFF);
        do_read(5'h06, 32'h1234_5678, "R9 div untouched");
        do_read(5'h0C, 32'h1, "R9 ctrl untouched");
        do_read(5'h10, 32'h8000_0001, "R9 dbg untouched");
        do_write(5'h08, 32'h6);
        do_read(5'h08, 32'h1, "R5 both cleared");
        cycle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule